// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces the frequency-offset word that a clock synthesizer adds to its feedback divider setting in order to sweep its output frequency slowly up and down and so spread the emitted energy over a band. The offset is a signed integer in units of 0.01 % of the nominal frequency. It follows a triangular profile whose peak-to-peak depth is 150 units, that is 1.5 % of nominal. The profile advances by one unit every `PRESCALE` reference clocks.

Two inputs choose the behaviour. `ss_en_n` is active low: a low level asks for modulation and a high level asks for a steady, unmodulated frequency. `ss_type_down` picks the shape while modulation is on. Low gives a swing centred on nominal. High gives a swing that stays at or below nominal. The combination of disable and down-type is not allowed. The block treats it as unmodulated and reports it on a flag. A requested change of shape, and a request to stop, is taken up only on a cycle where the offset is zero, so the synthesizer never sees a jump in frequency. Stopping always leaves the phase of the profile at its start.

Top module: `ssm_profile_gen`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `offset_o` is 0, `mod_active_o` is 0 and `bad_combo_o` is 0.
- R2: The requested mode is center when `ss_en_n`=0 and `ss_type_down`=0, down when `ss_en_n`=0 and `ss_type_down`=1, and unmodulated when `ss_en_n`=1. `mod_active_o` is 1 exactly while the adopted mode is center or down.
- R3: In center mode the offset starts at 0, rises by one unit per step to +75, falls to -75 and rises back to 0. One period is 300 steps.
- R4: In down mode the offset starts at 0, falls by one unit per step to -150 and rises back to 0. One period is 300 steps, and the offset is never positive.
- R5: A step happens every `PRESCALE` clocks. The first step comes on the `PRESCALE`-th rising edge after the edge that adopts a new modulated mode.
- R6: With `ss_en_n`=1 and `ss_type_down`=1, `bad_combo_o` is 1 from the next clock edge and the request is treated as unmodulated. Otherwise `bad_combo_o` is 0 from the next edge.
- R7: A requested mode that differs from the adopted one is adopted on the first clock edge at which `offset_o` is 0. Until then the running profile continues unchanged.
- R8: In unmodulated mode `offset_o` stays 0. A later enable restarts the profile at step 0: the first step is +1 for center and -1 for down.
- R9: `offset_o` never changes by more than one unit between consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ss_en_n | input | 1 | Modulation enable, active low |
| ss_type_down | input | 1 | Spread shape: 0 center, 1 down (to be tied low when unused) |
| offset_o | output | OFS_W (9) | Signed frequency offset in units of 0.01 % |
| mod_active_o | output | 1 | High while a modulated mode is adopted |
| bad_combo_o | output | 1 | High while the disallowed input combination is present |

## Verification
A wrong direction bit or a wrong turning point shows at `offset_o` within one step, as a value past ±75 or above 0, or as a reversal at the wrong peak. A prescaler that is off by one moves every later step by one cycle against the reference sequence, and the error grows from there. A mode register taken up away from zero shows at once as a jump greater than one unit. If it is taken up late, the offset follows the old shape past a zero crossing, which is visible on the following step. The bench predicts the full offset, active-flag and error-flag sequence for every cycle across center, down, deferred switching, stopping and the disallowed input combination.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    typedef enum logic [1:0] {
        MODE_OFF    = 2'd0,
        MODE_CENTER = 2'd1,
        MODE_DOWN   = 2'd2
    } ssm_mode_e;

    typedef struct packed {
        ssm_mode_e mode;
        logic      illegal;
    } ssm_req_t;

    function automatic ssm_req_t decode_req(input logic en_n, input logic down);
        ssm_req_t r;
        r.illegal = en_n & down;
        if (en_n)
            r.mode = MODE_OFF;
        else if (down)
            r.mode = MODE_DOWN;
        else
            r.mode = MODE_CENTER;
        return r;
    endfunction

endpackage

// File: rtl/ssm_mode_decode.sv
module ssm_mode_decode
    import ssm_pkg::*;
(
    input  logic     en_n,
    input  logic     type_down,
    output ssm_req_t req
);
    always_comb begin
        req = decode_req(en_n, type_down);
    end
endmodule

// File: rtl/ssm_prescaler.sv
module ssm_prescaler #(
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(PRESCALE + 1);
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    assign tick = run && !clr && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr || !run)
            cnt_q <= '0;
        else if (cnt_q == LAST)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    generate
        if (PRESCALE >= 2) begin : g_gap
            // R5: two steps are never on adjacent cycles
            a_r5_tick_gap: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ssm_tri_engine.sv
module ssm_tri_engine
    import ssm_pkg::*;
#(
    parameter int OFS_W       = 9,
    parameter int CENTER_HALF = 75,
    parameter int DOWN_DEPTH  = 150
) (
    input  logic                    clk,
    input  logic                    rst,
    input  ssm_mode_e               req_mode,
    input  logic                    tick,
    output logic                    switch_o,
    output ssm_mode_e               mode_o,
    output logic signed [OFS_W-1:0] ofs_o
);
    typedef struct packed {
        ssm_mode_e               mode;
        logic                    up;
        logic signed [OFS_W-1:0] ofs;
    } prof_t;

    prof_t st_q, st_d;
    int    hi, lo;
    logic  at_zero;

    always_comb begin
        unique case (st_q.mode)
            MODE_CENTER: begin hi = CENTER_HALF; lo = -CENTER_HALF; end
            MODE_DOWN:   begin hi = 0;           lo = -DOWN_DEPTH;  end
            default:     begin hi = 0;           lo = 0;            end
        endcase
        at_zero  = (st_q.ofs == '0);
        switch_o = at_zero && (req_mode != st_q.mode);

        st_d = st_q;
        if (switch_o) begin
            st_d.mode = req_mode;
            st_d.up   = (req_mode == MODE_CENTER);
        end else if (tick) begin
            if (st_q.up) begin
                if (int'(st_q.ofs) >= hi) begin
                    st_d.up  = 1'b0;
                    st_d.ofs = st_q.ofs - 1'b1;
                end else begin
                    st_d.ofs = st_q.ofs + 1'b1;
                end
            end else begin
                if (int'(st_q.ofs) <= lo) begin
                    st_d.up  = 1'b1;
                    st_d.ofs = st_q.ofs + 1'b1;
                end else begin
                    st_d.ofs = st_q.ofs - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.mode <= MODE_OFF;
            st_q.up   <= 1'b1;
            st_q.ofs  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;
    assign ofs_o  = st_q.ofs;

    a_r9_unit_step: assert property (@(posedge clk) disable iff (rst)
        (int'(ofs_o) - int'($past(ofs_o)) <= 1) && (int'($past(ofs_o)) - int'(ofs_o) <= 1));
    a_r7_switch_at_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |-> ($past(ofs_o) == '0));
    a_r8_off_holds_zero: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_OFF) |-> (ofs_o == '0));
    a_r3_center_bounds: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_CENTER) |-> (int'(ofs_o) <= CENTER_HALF && int'(ofs_o) >= -CENTER_HALF));
    a_r4_down_bounds: assert property (@(posedge clk) disable iff (rst)
        (mode_o == MODE_DOWN) |-> (int'(ofs_o) <= 0 && int'(ofs_o) >= -DOWN_DEPTH));
endmodule

// File: rtl/ssm_profile_gen.sv
module ssm_profile_gen
    import ssm_pkg::*;
#(
    parameter int OFS_W       = 9,
    parameter int PRESCALE    = 16,
    parameter int CENTER_HALF = 75,
    parameter int DOWN_DEPTH  = 150
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ss_en_n,
    input  logic                    ss_type_down,
    output logic signed [OFS_W-1:0] offset_o,
    output logic                    mod_active_o,
    output logic                    bad_combo_o
);
    ssm_req_t  req;
    ssm_mode_e cur_mode;
    logic      step_tick;
    logic      mode_switch;
    logic      bad_q;

    ssm_mode_decode u_dec (
        .en_n      (ss_en_n),
        .type_down (ss_type_down),
        .req       (req)
    );

    ssm_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (mode_switch),
        .run  (cur_mode != MODE_OFF),
        .tick (step_tick)
    );

    ssm_tri_engine #(
        .OFS_W       (OFS_W),
        .CENTER_HALF (CENTER_HALF),
        .DOWN_DEPTH  (DOWN_DEPTH)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .req_mode (req.mode),
        .tick     (step_tick),
        .switch_o (mode_switch),
        .mode_o   (cur_mode),
        .ofs_o    (offset_o)
    );

    always_ff @(posedge clk) begin
        if (rst)
            bad_q <= 1'b0;
        else
            bad_q <= req.illegal;
    end

    assign bad_combo_o  = bad_q;
    assign mod_active_o = (cur_mode != MODE_OFF);

    a_r6_bad_flag: assert property (@(posedge clk) disable iff (rst)
        (ss_en_n && ss_type_down) |=> bad_combo_o);
    a_r6_bad_never_modulates: assert property (@(posedge clk) disable iff (rst)
        (ss_en_n && ss_type_down && offset_o == '0) |=> !mod_active_o);
endmodule

// File: tb/ssm_profile_gen_tb_top.sv
`timescale 1ns/1ps
module ssm_profile_gen_tb_top;
    localparam int P = 2;
    localparam int W = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en_n = 1'b1;
    logic tdown = 1'b0;
    logic signed [W-1:0] ofs;
    logic act, bad;

    always #2.5 clk = ~clk;

    ssm_profile_gen #(.OFS_W(W), .PRESCALE(P)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .ss_en_n      (en_n),
        .ss_type_down (tdown),
        .offset_o     (ofs),
        .mod_active_o (act),
        .bad_combo_o  (bad)
    );

    typedef struct {
        int    cyc;
        int    ofs;
        bit    act;
        bit    bad;
        string tag;
    } item_t;

    item_t q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_mode = 0, m_k = 0, m_sub = 0;
    int prev_ofs = 0;
    bit have_prev = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int tri_val(input int mode, input int k);
        if (mode == 1) begin
            if (k <= 75) return k;
            else if (k <= 225) return 150 - k;
            else return k - 300;
        end else if (mode == 2) begin
            if (k <= 150) return -k;
            else return k - 300;
        end
        return 0;
    endfunction

    // driver: called 1 ns after a rising edge
    task automatic drive(input bit e, input bit t, input string tag);
        int req, v;
        item_t it;
        en_n  = e;
        tdown = t;
        req = e ? 0 : (t ? 2 : 1);
        v = tri_val(m_mode, m_k);
        if (v == 0 && req != m_mode) begin
            m_mode = req; m_k = 0; m_sub = 0;
        end else if (m_mode != 0) begin
            m_sub++;
            if (m_sub == P) begin m_sub = 0; m_k = (m_k + 1) % 300; end
        end
        it.cyc = cyc + 1;
        it.ofs = tri_val(m_mode, m_k);
        it.act = (m_mode != 0);
        it.bad = e && t;
        it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic phase(input bit e, input bit t, input int n, input string tag);
        for (int i = 0; i < n; i++) drive(e, t, tag);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (q.size() > 0 && q[0].cyc == cyc) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (int'(ofs) != it.ofs || act != it.act || bad != it.bad) begin
                    errors++;
                    $display("FAIL %s cyc=%0d: ofs/act/bad = %0d/%0b/%0b expected %0d/%0b/%0b",
                             it.tag, cyc, int'(ofs), act, bad, it.ofs, it.act, it.bad);
                end
            end
            if (have_prev) begin
                checks++;
                if (int'(ofs) - prev_ofs > 1 || prev_ofs - int'(ofs) > 1) begin
                    errors++;
                    $display("FAIL R9 unit step: ofs=%0d after %0d, expected difference <= 1",
                             int'(ofs), prev_ofs);
                end
            end
            prev_ofs = int'(ofs);
            have_prev = 1;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (ofs !== '0 || act !== 1'b0 || bad !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: ofs/act/bad = %0d/%0b/%0b expected 0/0/0", int'(ofs), act, bad);
        end
        rst = 1'b0;
        phase(1, 0, 6,   "R1 first cycles / R2 disabled steady");
        phase(0, 0, 5,   "R5 first step timing");
        phase(0, 0, 650, "R3 center triangle");
        phase(0, 1, 700, "R7 deferred switch center to down");
        phase(1, 0, 400, "R8 stop returns to nominal");
        phase(0, 1, 650, "R4 down triangle from stop");
        phase(1, 1, 400, "R6 disallowed combination mid-run");
        phase(0, 0, 60,  "R2 center restart after stop");
        phase(1, 1, 10,  "R6 disallowed combination while stopped");
        phase(1, 0, 4,   "R6 flag clears");
        @(negedge clk); #1;
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R2 scoreboard drain: %0d left, expected 0", q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule